// File: doc/BRIEF.md
# Block CRC Inserter and Checker

This block sits in the byte path of a four-level FSK data modem and handles the error-detection codes of its fixed-size framing. Each block is twelve bytes long and is one of three kinds: a header, an intermediate block or a last block. A header block carries its own 16-bit CRC in its final two bytes. A 32-bit CRC runs across a whole message. It takes in every byte of every intermediate block and the first eight bytes of the last block, and it sits in the last four bytes of the last block.

Bytes enter on a valid/ready stream and leave on a second valid/ready stream one register stage later. A byte moves only when both valid and ready are high on a rising clock edge. The input is ready whenever the output register is empty or is being drained in the same cycle. A held byte must keep its data stable. The direction level `tx_mode` selects the mode. In transmit mode the block replaces the CRC positions of the outgoing stream with the computed code. In receive mode it forwards every byte unchanged, compares the received CRC bytes with the computed code and pulses a pass or fail flag.

The 32-bit register is not cleared at block boundaries. It is cleared only by a task-completion strobe, and the task code together with the direction decides whether the clear happens.

Top module: `pkt_crc_engine`

## Requirements
- R1: The header CRC uses polynomial 0x1021 (x^16+x^12+x^5+1) with a preset of 0xFFFF. It shifts each byte in most-significant bit first, covers header bytes 0 to 9 only, starts afresh at every header block and has no final inversion.
- R2: In transmit mode, header output bytes 10 and 11 carry the header CRC, high byte first. Bytes 0 to 9 pass through unchanged.
- R3: In receive mode, on the cycle after header byte 11 is accepted, exactly one of `hdr_ok` (bytes 10 and 11 equal the CRC, high byte first) or `hdr_err` is high for one cycle.
- R4: The long CRC uses polynomial 0x04C11DB7 with a preset of 0xFFFFFFFF and shifts each byte in most-significant bit first. It accumulates all 12 bytes of every intermediate block and bytes 0 to 7 of a last block. Header bytes leave it untouched, and block ends do not clear it.
- R5: In transmit mode, last-block output bytes 8 to 11 carry the long CRC, most significant byte first.
- R6: In receive mode, on the cycle after last-block byte 11 is accepted, exactly one of `last_ok` or `last_err` is high for one cycle, according to whether bytes 8 to 11 equal the long CRC.
- R7: In receive mode (`tx_mode`=0), a `task_done` pulse presets the long CRC unless `task_code` is 0 (null) or 3 (receive intermediate-or-last block). Codes 1 and 2 do clear in receive mode.
- R8: In transmit mode, a `task_done` pulse presets the long CRC unless `task_code` is 0 (null), 1 (transmit intermediate block) or 2 (transmit last block). Code 3 does clear in transmit mode.
- R9: Accepted bytes are counted 0 to 11 within a block. The block kind is taken from `in_kind` on byte 0: 0 header, 1 intermediate, 2 last, 3 treated as intermediate.
- R10: `in_ready` = !`out_valid` || `out_ready`. Each accepted byte appears on `out_data` one cycle later. A held output keeps `out_valid` and `out_data` stable. Cycles with no accepted byte change neither CRC. Receive mode forwards every byte unchanged.
- R11: Synchronous reset empties the output stage, presets both CRCs, returns the byte position to 0 and clears all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tx_mode | input | 1 | 1 transmit, 0 receive |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_kind | input | 2 | Block kind, sampled on byte 0 |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take the output byte |
| out_data | output | 8 | Output byte |
| task_done | input | 1 | Task-completion strobe |
| task_code | input | 3 | Code of the completed task |
| hdr_ok | output | 1 | Header CRC matched (pulse) |
| hdr_err | output | 1 | Header CRC mismatched (pulse) |
| last_ok | output | 1 | Long CRC matched (pulse) |
| last_err | output | 1 | Long CRC mismatched (pulse) |

## Verification
A header placed between two intermediate blocks must leave the long CRC alone. A design that folds header bytes into it emits a wrong last-block code. The clear rules are walked code by code in both directions, including codes 1 and 2 in receive mode and code 3 in transmit mode. A design that applies one exemption list to both directions keeps stale state or wipes a running CRC, and the last-block code comes out wrong. Output back-pressure during a long message catches a design that updates a CRC on a stalled byte, because that corrupts the inserted code. A reset in the middle of a block catches a position counter or CRC that survives reset, because the next header then gets a misplaced or wrong code. Single corrupted CRC bytes in receive mode must raise the error flag and not the pass flag.

// File: rtl/pkt_crc_pkg.sv
package pkt_crc_pkg;
  typedef enum logic [1:0] {
    KIND_HDR  = 2'd0,
    KIND_MID  = 2'd1,
    KIND_LAST = 2'd2,
    KIND_RSV  = 2'd3
  } blk_kind_e;

  localparam int TASK_W = 3;
  localparam logic [TASK_W-1:0] TASK_NULL    = 3'd0;
  localparam logic [TASK_W-1:0] TASK_TX_MID  = 3'd1;
  localparam logic [TASK_W-1:0] TASK_TX_LAST = 3'd2;
  localparam logic [TASK_W-1:0] TASK_RX_BLK  = 3'd3;
endpackage

// File: rtl/crc_accum.sv
module crc_accum #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [7:0]   din,
  output logic [W-1:0] crc_q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = clr ? INIT : crc_q;
    for (int i = 7; i >= 0; i--) begin
      if (nxt[W-1] ^ din[i]) nxt = {nxt[W-2:0], 1'b0} ^ POLY;
      else                   nxt = {nxt[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      crc_q <= INIT;
    else if (en)  crc_q <= nxt;
    else if (clr) crc_q <= INIT;
  end
endmodule

// File: rtl/pkt_pos_tracker.sv
module pkt_pos_tracker import pkt_crc_pkg::*; #(
  parameter int BLK_BYTES = 12,
  parameter int PW = $clog2(BLK_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  blk_kind_e     kind_in,
  output logic [PW-1:0] pos,
  output blk_kind_e     kind_cur,
  output logic          at_end
);
  blk_kind_e kind_q;

  assign kind_cur = (pos == '0) ? kind_in : kind_q;
  assign at_end   = (pos == PW'(BLK_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      kind_q <= KIND_HDR;
    end else if (adv) begin
      pos <= at_end ? '0 : pos + 1'b1;
      if (pos == '0) kind_q <= kind_in;
    end
  end
endmodule

// File: rtl/pkt_long_clear.sv
module pkt_long_clear import pkt_crc_pkg::*; (
  input  logic              task_done,
  input  logic [TASK_W-1:0] task_code,
  input  logic              tx,
  output logic              clr
);
  logic exempt;

  always_comb begin
    if (task_code == TASK_NULL) exempt = 1'b1;
    else if (tx) exempt = (task_code == TASK_TX_MID) || (task_code == TASK_TX_LAST);
    else         exempt = (task_code == TASK_RX_BLK);
    clr = task_done && !exempt;
  end
endmodule

// File: rtl/pkt_crc_engine.sv
module pkt_crc_engine import pkt_crc_pkg::*; #(
  parameter int BLK_BYTES = 12,
  parameter int HDR_W = 16,
  parameter int LONG_W = 32,
  parameter logic [HDR_W-1:0]  HDR_POLY  = 16'h1021,
  parameter logic [LONG_W-1:0] LONG_POLY = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [1:0]        in_kind,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  input  logic              task_done,
  input  logic [TASK_W-1:0] task_code,
  output logic              hdr_ok,
  output logic              hdr_err,
  output logic              last_ok,
  output logic              last_err
);
  localparam int HDR_B        = HDR_W / 8;
  localparam int LONG_B       = LONG_W / 8;
  localparam int HDR_CRC_POS  = BLK_BYTES - HDR_B;
  localparam int LAST_CRC_POS = BLK_BYTES - LONG_B;
  localparam int PW           = $clog2(BLK_BYTES);

  logic              accept;
  logic [PW-1:0]     pos;
  blk_kind_e         kind;
  logic              at_end;
  logic [HDR_W-1:0]  hdr_crc;
  logic [LONG_W-1:0] long_crc;
  logic              long_clr;
  logic              is_hdr, is_last;
  logic              hdr_body, hdr_chk, long_body, last_chk, chk_first;
  int                k_hdr, k_long;
  logic [7:0]        exp_byte, tx_byte;
  logic              mis_q, bad_all;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  pkt_pos_tracker #(.BLK_BYTES(BLK_BYTES), .PW(PW)) u_pos (
    .clk(clk), .rst(rst), .adv(accept), .kind_in(blk_kind_e'(in_kind)),
    .pos(pos), .kind_cur(kind), .at_end(at_end)
  );

  pkt_long_clear u_clr (
    .task_done(task_done), .task_code(task_code), .tx(tx_mode), .clr(long_clr)
  );

  always_comb begin
    is_hdr    = (kind == KIND_HDR);
    is_last   = (kind == KIND_LAST);
    hdr_body  = is_hdr && (int'(pos) < HDR_CRC_POS);
    hdr_chk   = is_hdr && !hdr_body;
    long_body = !is_hdr && !(is_last && int'(pos) >= LAST_CRC_POS);
    last_chk  = is_last && (int'(pos) >= LAST_CRC_POS);
    chk_first = (hdr_chk && int'(pos) == HDR_CRC_POS) ||
                (last_chk && int'(pos) == LAST_CRC_POS);
    k_hdr     = hdr_chk  ? (BLK_BYTES - 1 - int'(pos)) : 0;
    k_long    = last_chk ? (BLK_BYTES - 1 - int'(pos)) : 0;
    exp_byte  = hdr_chk ? 8'(hdr_crc >> (8 * k_hdr)) : 8'(long_crc >> (8 * k_long));
    tx_byte   = (tx_mode && (hdr_chk || last_chk)) ? exp_byte : in_data;
    bad_all   = (chk_first ? 1'b0 : mis_q) | (in_data != exp_byte);
  end

  crc_accum #(.W(HDR_W), .POLY(HDR_POLY), .INIT('1)) u_hdr_crc (
    .clk(clk), .rst(rst), .clr(accept && hdr_body && pos == '0),
    .en(accept && hdr_body), .din(in_data), .crc_q(hdr_crc)
  );

  crc_accum #(.W(LONG_W), .POLY(LONG_POLY), .INIT('1)) u_long_crc (
    .clk(clk), .rst(rst), .clr(long_clr),
    .en(accept && long_body), .din(in_data), .crc_q(long_crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      mis_q     <= 1'b0;
      hdr_ok    <= 1'b0;
      hdr_err   <= 1'b0;
      last_ok   <= 1'b0;
      last_err  <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= tx_byte;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (accept && (hdr_chk || last_chk)) mis_q <= bad_all;
      hdr_ok   <= accept && at_end && !tx_mode && is_hdr  && !bad_all;
      hdr_err  <= accept && at_end && !tx_mode && is_hdr  &&  bad_all;
      last_ok  <= accept && at_end && !tx_mode && is_last && !bad_all;
      last_err <= accept && at_end && !tx_mode && is_last &&  bad_all;
    end
  end
endmodule

// File: rtl/pkt_crc_engine_chk.sv
module pkt_crc_engine_chk #(
  parameter int HDR_W = 16,
  parameter int LONG_W = 32,
  parameter int PW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              hdr_ok,
  input logic              hdr_err,
  input logic              last_ok,
  input logic              last_err,
  input logic [HDR_W-1:0]  hdr_crc,
  input logic [LONG_W-1:0] long_crc,
  input logic              long_clr,
  input logic [PW-1:0]     pos
);
  p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_idle_crc_r10: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) && !long_clr |=> $stable(hdr_crc) && $stable(long_crc));

  p_ready_rule_r10: assert property (@(posedge clk) disable iff (rst)
    in_ready == (!out_valid || out_ready));

  p_flag_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hdr_ok, hdr_err, last_ok, last_err}));

  p_flag_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (hdr_ok || hdr_err || last_ok || last_err) |-> $past(in_valid && in_ready));

  p_long_preset_r8: assert property (@(posedge clk) disable iff (rst)
    long_clr && !(in_valid && in_ready) |=> long_crc == '1);

  p_reset_state_r11: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && pos == '0 && hdr_crc == '1 && long_crc == '1);
endmodule

bind pkt_crc_engine pkt_crc_engine_chk #(.HDR_W(HDR_W), .LONG_W(LONG_W), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .hdr_ok(hdr_ok), .hdr_err(hdr_err), .last_ok(last_ok), .last_err(last_err),
  .hdr_crc(hdr_crc), .long_crc(long_crc), .long_clr(long_clr), .pos(pos)
);

// File: tb/pkt_crc_engine_tb.sv
module pkt_crc_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, tx_mode = 1'b1;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [7:0] in_data = '0, out_data;
  logic [1:0] in_kind = '0;
  logic task_done = 1'b0;
  logic [2:0] task_code = '0;
  logic hdr_ok, hdr_err, last_ok, last_err;

  int errors = 0, checks = 0, cyc = 0;
  bit stall_on = 1'b0;
  logic [7:0] got[$];
  logic [31:0] lm;

  pkt_crc_engine u_dut (
    .clk(clk), .rst(rst), .tx_mode(tx_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_kind(in_kind), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .task_done(task_done), .task_code(task_code),
    .hdr_ok(hdr_ok), .hdr_err(hdr_err), .last_ok(last_ok), .last_err(last_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready <= !(stall_on && (cyc % 3 == 1));
  end

  always @(negedge clk) if (out_valid && out_ready) got.push_back(out_data);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m16(input logic [15:0] c, input logic [7:0] d);
    for (int i = 7; i >= 0; i--) c = {c[14:0], 1'b0} ^ ((c[15] ^ d[i]) ? 16'h1021 : 16'h0);
    return c;
  endfunction

  function automatic logic [31:0] m32(input logic [31:0] c, input logic [7:0] d);
    for (int i = 7; i >= 0; i--) c = {c[30:0], 1'b0} ^ ((c[31] ^ d[i]) ? 32'h04C11DB7 : 32'h0);
    return c;
  endfunction

  task automatic fill(input int seed, output logic [7:0] b [12]);
    for (int i = 0; i < 12; i++) b[i] = 8'((seed * 37 + i * 53 + i * i) ^ 8'h5A);
  endtask

  task automatic fold32(input logic [7:0] b [12], input int n);
    for (int i = 0; i < n; i++) lm = m32(lm, b[i]);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic [1:0] k);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_kind = k;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_block(input logic [1:0] k, input logic [7:0] b [12], output logic [3:0] fl);
    got.delete();
    for (int i = 0; i < 12; i++) send_byte(b[i], k);
    @(negedge clk);
    fl = {hdr_ok, hdr_err, last_ok, last_err};
    for (int i = 0; i < 60 && got.size() < 12; i++) @(negedge clk);
  endtask

  task automatic cmp_out(input string tag, input logic [7:0] eb [12]);
    chk(got.size() == 12, {tag, " count"}, 32'(got.size()), 32'd12);
    for (int i = 0; i < 12 && i < got.size(); i++)
      chk(got[i] == eb[i], $sformatf("%s byte%0d", tag, i), {24'h0, got[i]}, {24'h0, eb[i]});
  endtask

  task automatic pulse_task(input logic [2:0] code);
    @(negedge clk); task_done = 1'b1; task_code = code;
    @(negedge clk); task_done = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!out_valid && in_ready, "R11 reset outputs", {30'h0, out_valid, in_ready}, 32'h1);
    chk({hdr_ok, hdr_err, last_ok, last_err} == 4'h0, "R11 reset flags",
        {28'h0, hdr_ok, hdr_err, last_ok, last_err}, 32'h0);
    do_reset();
  endtask

  task automatic t_model;
    logic [15:0] c16 = 16'hFFFF;
    logic [31:0] c32 = 32'hFFFFFFFF;
    for (int i = 0; i < 9; i++) begin
      c16 = m16(c16, 8'h31 + 8'(i));
      c32 = m32(c32, 8'h31 + 8'(i));
    end
    chk(c16 == 16'h29B1, "R1 model check value", {16'h0, c16}, 32'h29B1);
    chk(c32 == 32'h0376E6E7, "R4 model check value", c32, 32'h0376E6E7);
  endtask

  task automatic t_tx_header(input int seed);
    logic [7:0] b [12], eb [12];
    logic [3:0] fl;
    logic [15:0] c = 16'hFFFF;
    tx_mode = 1'b1;
    fill(seed, b);
    for (int i = 0; i < 10; i++) c = m16(c, b[i]);
    eb = b; eb[10] = c[15:8]; eb[11] = c[7:0];
    send_block(2'd0, b, fl);
    cmp_out("R2 R1 R9 tx header", eb);
    chk(fl == 4'h0, "R3 no flags in tx", {28'h0, fl}, 32'h0);
  endtask

  task automatic t_rx_header;
    logic [7:0] b [12];
    logic [3:0] fl;
    logic [15:0] c = 16'hFFFF;
    tx_mode = 1'b0;
    fill(11, b);
    for (int i = 0; i < 10; i++) c = m16(c, b[i]);
    b[10] = c[15:8]; b[11] = c[7:0];
    send_block(2'd0, b, fl);
    chk(fl == 4'b1000, "R3 rx header good", {28'h0, fl}, 32'h8);
    cmp_out("R10 rx passthrough", b);
    b[11] = b[11] ^ 8'h01;
    send_block(2'd0, b, fl);
    chk(fl == 4'b0100, "R3 rx header bad low", {28'h0, fl}, 32'h4);
    b[11] = b[11] ^ 8'h01; b[10] = b[10] ^ 8'h80;
    send_block(2'd0, b, fl);
    chk(fl == 4'b0100, "R3 rx header bad high", {28'h0, fl}, 32'h4);
  endtask

  task automatic t_tx_long;
    logic [7:0] a [12], h [12], m [12], l [12], el [12];
    logic [3:0] fl;
    tx_mode = 1'b1; stall_on = 1'b1;
    pulse_task(3'd4);
    fill(21, a); fill(22, h); fill(23, m); fill(24, l);
    lm = '1; fold32(a, 12); fold32(m, 12); fold32(l, 8);
    send_block(2'd1, a, fl);
    cmp_out("R10 tx mid passthrough stalled", a);
    send_block(2'd0, h, fl);
    send_block(2'd3, m, fl);
    el = l; for (int i = 0; i < 4; i++) el[8+i] = lm[31-8*i -: 8];
    send_block(2'd2, l, fl);
    cmp_out("R4 R5 R10 tx last over header gap", el);
    stall_on = 1'b0;
  endtask

  task automatic t_rx_long;
    logic [7:0] m [12], l [12];
    logic [3:0] fl;
    tx_mode = 1'b0;
    pulse_task(3'd5);
    fill(31, m); fill(32, l);
    lm = '1; fold32(m, 12); fold32(l, 8);
    for (int i = 0; i < 4; i++) l[8+i] = lm[31-8*i -: 8];
    send_block(2'd1, m, fl);
    chk(fl == 4'h0, "R6 no flag on mid", {28'h0, fl}, 32'h0);
    send_block(2'd2, l, fl);
    chk(fl == 4'b0010, "R6 rx last good", {28'h0, fl}, 32'h2);
    pulse_task(3'd6);
    lm = '1; fold32(l, 8);
    for (int i = 0; i < 4; i++) l[8+i] = lm[31-8*i -: 8];
    l[9] = l[9] ^ 8'h10;
    send_block(2'd2, l, fl);
    chk(fl == 4'b0001, "R6 rx last bad", {28'h0, fl}, 32'h1);
  endtask

  task automatic t_rx_clear;
    logic [7:0] m [12], l [12];
    logic [3:0] fl;
    tx_mode = 1'b0;
    pulse_task(3'd7);
    fill(41, m); fill(42, l);
    send_block(2'd1, m, fl);
    pulse_task(3'd3);
    pulse_task(3'd0);
    lm = '1; fold32(m, 12); fold32(l, 8);
    for (int i = 0; i < 4; i++) l[8+i] = lm[31-8*i -: 8];
    send_block(2'd2, l, fl);
    chk(fl == 4'b0010, "R7 rx codes 3 and 0 keep CRC", {28'h0, fl}, 32'h2);
    pulse_task(3'd1);
    lm = '1; fold32(l, 8);
    for (int i = 0; i < 4; i++) l[8+i] = lm[31-8*i -: 8];
    send_block(2'd2, l, fl);
    chk(fl == 4'b0010, "R7 rx code 1 clears", {28'h0, fl}, 32'h2);
    pulse_task(3'd2);
    send_block(2'd2, l, fl);
    chk(fl == 4'b0010, "R7 rx code 2 clears", {28'h0, fl}, 32'h2);
  endtask

  task automatic t_tx_clear;
    logic [7:0] m [12], l1 [12], l2 [12], l3 [12], e [12];
    logic [3:0] fl;
    tx_mode = 1'b1;
    pulse_task(3'd4);
    fill(51, m); fill(52, l1); fill(53, l2); fill(54, l3);
    send_block(2'd1, m, fl);
    pulse_task(3'd1);
    pulse_task(3'd2);
    lm = '1; fold32(m, 12); fold32(l1, 8);
    e = l1; for (int i = 0; i < 4; i++) e[8+i] = lm[31-8*i -: 8];
    send_block(2'd2, l1, fl);
    cmp_out("R8 tx codes 1 and 2 keep CRC", e);
    pulse_task(3'd0);
    fold32(l2, 8);
    e = l2; for (int i = 0; i < 4; i++) e[8+i] = lm[31-8*i -: 8];
    send_block(2'd2, l2, fl);
    cmp_out("R4 R8 CRC runs past last block", e);
    pulse_task(3'd3);
    lm = '1; fold32(l3, 8);
    e = l3; for (int i = 0; i < 4; i++) e[8+i] = lm[31-8*i -: 8];
    send_block(2'd2, l3, fl);
    cmp_out("R8 tx code 3 clears", e);
  endtask

  task automatic t_mid_reset;
    tx_mode = 1'b1;
    for (int i = 0; i < 5; i++) send_byte(8'hA0 + 8'(i), 2'd0);
    do_reset();
    got.delete();
    @(negedge clk);
    chk(!out_valid, "R11 output empty after reset", {31'h0, out_valid}, 32'h0);
    t_tx_header(61);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_model();
    t_tx_header(1);
    t_rx_header();
    t_tx_long();
    t_rx_long();
    t_rx_clear();
    t_tx_clear();
    t_mid_reset();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule